// File: doc/BRIEF.md
# Strobed FIFO with Retransmit

This block is a first-in first-out word buffer, 4096 entries of nine bits by default, whose producer and consumer each present one active-low strobe. The strobes are brought into the system clock domain by synchronisers, and only the high-to-low transition of each synchronised strobe counts as an operation. The ninth bit of every word is carried through untouched, so it can hold a parity or framing mark chosen by the user of the buffer.

Three active-low status outputs report the fill level: empty, full, and more-than-half. A write into a full buffer and a read from an empty buffer are both dropped without side effects. In standalone operation, a shared control input rewinds the read side to the first stored location, so a message can be sent again. This works only while the write side has not yet gone once around the storage.

When the chain input is high, several buffers can be chained for depth. A write token then decides which buffer accepts words. The shared control input, held low through reset, marks the buffer that owns the token first. The buffer hands the token on with a one-cycle low pulse on the pin that otherwise reports half-full, and it takes the token back on a falling edge at its expansion input.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low and in the first cycles after it, empty_n is 0, full_n is 1, half_xo_n is 1 and dout is 0.
- R2: Words come out of dout in the order they were written, with all nine bits, including bit 8, unchanged.
- R3: A write strobe while DEPTH words are stored is ignored: full_n stays 0 and the stored words read back unchanged.
- R4: A read strobe while no word is stored is ignored: empty_n stays 0 and dout keeps its value.
- R5: empty_n is 0 exactly when zero words are stored, and full_n is 0 exactly when DEPTH words are stored.
- R6: With expand_en low, half_xo_n is 0 exactly when more than DEPTH/2 words are stored.
- R7: With expand_en low, a falling edge on load_rt_n sets the read position to location 0 and the stored count to the number of words written since reset, so the next reads replay from the first word.
- R8: A falling edge on load_rt_n is ignored once DEPTH or more writes have been accepted since reset.
- R9: A write and a read whose falling edges fall in the same cycle, both allowed, leave the stored count unchanged.
- R10: With expand_en high, half_xo_n gives one low pulse of one cycle each time an accepted write moves the write position from DEPTH-1 to 0, and it is 1 at all other times.
- R11: With expand_en high, writes are accepted only while the buffer holds the write token. It holds the token after reset if load_rt_n was low during reset, loses it on the wrap of R10, and gains it on a falling edge of xi_n.
- R12: Each strobe acts once per falling edge, however long it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low synchronous reset of pointers and flags |
| expand_en | input | 1 | 1 selects chained depth mode, 0 standalone |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 9 | Word to store |
| rd_n | input | 1 | Active-low read strobe |
| dout | output | 9 | Last word read |
| load_rt_n | input | 1 | Active-low retransmit (standalone) or first-load mark during reset (chained) |
| xi_n | input | 1 | Active-low expansion input that grants the write token |
| full_n | output | 1 | Active-low full flag |
| half_xo_n | output | 1 | Active-low more-than-half flag, or expansion handoff pulse when chained |
| empty_n | output | 1 | Active-low empty flag |

## Verification
The hardest situation to bring about is the retransmit refusal of R8. It needs the write side to have gone all the way around the storage, so the bench runs with a sixteen-word configuration. It first does a legal rewind with a partial fill, then keeps writing past the wrap to full, and then strobes retransmit and checks that the next reads continue from the unread data. The token handoff of R11 is reached in the same way: the buffer is filled through a wrap, then drained by one word, and a refused write is followed by a granted one.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } fifo_mode_e;

    // one synchronised falling-edge event per strobe input
    typedef struct packed {
        logic xi;
        logic rt;
        logic rd;
        logic wr;
    } strobe_evt_t;

    localparam int STROBE_COUNT = 4;

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], strobe_n};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q.chain <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    // previous synchronised level high, present one low
    assign fall = sync_q.chain[CHAIN_W-1] & ~sync_q.chain[CHAIN_W-2];

endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  fifo_mode_e                 mode,
    input  logic                       first_load_n,
    input  strobe_evt_t                evt,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic                       rd_en,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       token,
    output logic                       full_n,
    output logic                       empty_n,
    output logic                       half_xo_n
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        logic             wrapped;
        logic             token;
        logic             xo;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  chain;
    logic  wr_ok, rd_ok, rt_ok;

    assign chain = (mode == MODE_CHAIN);

    always_comb begin
        st_d    = st_q;
        st_d.xo = 1'b0;

        wr_ok = evt.wr && (st_q.count != FULL_CNT) && (!chain || st_q.token);
        rt_ok = evt.rt && !chain && !st_q.wrapped;
        rd_ok = evt.rd && (st_q.count != '0) && !rt_ok;

        if (chain && evt.xi) begin
            st_d.token = 1'b1;
        end

        if (wr_ok) begin
            st_d.wptr = st_q.wptr + PTR_W'(1);
            if (st_q.wptr == LAST_PTR) begin
                st_d.wrapped = 1'b1;
                if (chain) begin
                    st_d.token = 1'b0;
                    st_d.xo    = 1'b1;
                end
            end
        end

        if (rt_ok) begin
            st_d.rptr  = '0;
            st_d.count = CNT_W'(st_q.wptr) + CNT_W'(wr_ok);
        end else begin
            if (rd_ok) begin
                st_d.rptr = st_q.rptr + PTR_W'(1);
            end
            st_d.count = st_q.count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wptr    <= '0;
            st_q.rptr    <= '0;
            st_q.count   <= '0;
            st_q.wrapped <= 1'b0;
            st_q.token   <= chain & ~first_load_n;
            st_q.xo      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = wr_ok;
    assign wr_addr   = st_q.wptr;
    assign rd_en     = rd_ok;
    assign rd_addr   = st_q.rptr;
    assign count     = st_q.count;
    assign token     = st_q.token;
    assign full_n    = (st_q.count != FULL_CNT);
    assign empty_n   = (st_q.count != '0);
    assign half_xo_n = chain ? ~st_q.xo : ~(st_q.count > HALF_CNT);

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DATA_W      = 9,
    parameter int DEPTH       = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expand_en,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_n,
    output logic [DATA_W-1:0] dout,
    input  logic              load_rt_n,
    input  logic              xi_n,
    output logic              full_n,
    output logic              half_xo_n,
    output logic              empty_n
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [STROBE_COUNT-1:0] raw_n;
    logic [STROBE_COUNT-1:0] falls;
    strobe_evt_t             evt;
    fifo_mode_e              mode;

    logic             wr_en, rd_en, token;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0] count;
    logic             wr_fall, rd_fall, rt_fall, xi_fall;

    assign raw_n = {xi_n, load_rt_n, rd_n, wr_n};
    assign mode  = fifo_mode_e'(expand_en);

    for (genvar g = 0; g < STROBE_COUNT; g++) begin : g_sync
        strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (raw_n[g]),
            .fall     (falls[g])
        );
    end

    assign evt     = strobe_evt_t'(falls);
    assign wr_fall = evt.wr;
    assign rd_fall = evt.rd;
    assign rt_fall = evt.rt;
    assign xi_fall = evt.xi;

    strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .first_load_n (load_rt_n),
        .evt          (evt),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .count        (count),
        .token        (token),
        .full_n       (full_n),
        .empty_n      (empty_n),
        .half_xo_n    (half_xo_n)
    );

    strobe_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (din),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (dout)
    );

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DATA_W = 9,
    parameter int CNT_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              expand_en,
    input logic              wr_fall,
    input logic              rd_fall,
    input logic              rt_fall,
    input logic              token,
    input logic [CNT_W-1:0]  count,
    input logic              full_n,
    input logic              empty_n,
    input logic              half_xo_n,
    input logic [DATA_W-1:0] dout
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_fall && !rt_fall) |=> !full_n);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_fall) |=> $stable(dout));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    assert_half_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!expand_en && !half_xo_n) |-> empty_n);

    assert_net_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fall && rd_fall && !rt_fall && full_n && empty_n && (!expand_en || token))
        |=> $stable(count));

    assert_xo_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_en && !half_xo_n) |=> half_xo_n);

    assert_no_token_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_en && !token && wr_fall && !rd_fall) |=> $stable(count));

endmodule

bind strobe_fifo strobe_fifo_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .expand_en (expand_en),
    .wr_fall   (wr_fall),
    .rd_fall   (rd_fall),
    .rt_fall   (rt_fall),
    .token     (token),
    .count     (count),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .half_xo_n (half_xo_n),
    .dout      (dout)
);

// File: tb/strobe_fifo_test.sv
`timescale 1ns/1ps
module strobe_fifo_test;
    localparam int D  = 16;
    localparam int W  = 9;
    localparam int HOLD = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         expand_en = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         load_rt_n = 1'b1;
    logic         xi_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         full_n, half_xo_n, empty_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    int  m_mem [D];
    int  m_wptr, m_rptr, m_cnt, m_dout, m_xo;
    bit  m_wrapped, m_token, m_chain;
    int  xo_seen;

    always #2.5 clk = ~clk;

    strobe_fifo #(.DATA_W(W), .DEPTH(D), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .expand_en(expand_en),
        .wr_n(wr_n), .din(din), .rd_n(rd_n), .dout(dout),
        .load_rt_n(load_rt_n), .xi_n(xi_n),
        .full_n(full_n), .half_xo_n(half_xo_n), .empty_n(empty_n)
    );

    always @(negedge clk) begin
        if (rst_n && expand_en && !half_xo_n) xo_seen++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        @(negedge clk);
        chk({req, " empty_n"}, empty_n, (m_cnt == 0) ? 0 : 1);
        chk({req, " full_n"},  full_n,  (m_cnt == D) ? 0 : 1);
        if (m_chain) chk({req, " half_xo_n idle R10"}, half_xo_n, 1);
        else         chk({req, " half_xo_n R6"}, half_xo_n, (m_cnt > D/2) ? 0 : 1);
        chk({req, " dout"}, dout, m_dout);
    endtask

    task automatic model_ops(bit w, bit r, int data);
        bit wa, ra;
        wa = w && (m_cnt < D) && (!m_chain || m_token);
        ra = r && (m_cnt > 0);
        if (wa) begin
            m_mem[m_wptr] = data;
            m_wptr = (m_wptr + 1) % D;
            if (m_wptr == 0) begin
                m_wrapped = 1;
                if (m_chain) begin m_token = 0; m_xo++; end
            end
        end
        if (ra) begin
            m_dout = m_mem[m_rptr];
            m_rptr = (m_rptr + 1) % D;
        end
        m_cnt = m_cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    endtask

    task automatic strobe(bit w, bit r, int data, int hold, string req);
        din = W'(data);
        if (w) wr_n = 1'b0;
        if (r) rd_n = 1'b0;
        repeat (hold) @(posedge clk);
        wr_n = 1'b1;
        rd_n = 1'b1;
        repeat (HOLD) @(posedge clk);
        model_ops(w, r, data);
        check_state(req);
    endtask

    task automatic retransmit(string req);
        load_rt_n = 1'b0;
        repeat (HOLD) @(posedge clk);
        load_rt_n = 1'b1;
        repeat (HOLD) @(posedge clk);
        if (!m_chain && !m_wrapped) begin
            m_rptr = 0;
            m_cnt  = m_wptr;
        end
        check_state(req);
    endtask

    task automatic pulse_xi();
        xi_n = 1'b0;
        repeat (HOLD) @(posedge clk);
        xi_n = 1'b1;
        repeat (HOLD) @(posedge clk);
        if (m_chain) m_token = 1;
    endtask

    task automatic do_reset(bit chain, bit first_load);
        rst_n = 1'b0;
        expand_en = chain;
        load_rt_n = first_load ? 1'b0 : 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        load_rt_n = 1'b1;
        m_wptr = 0; m_rptr = 0; m_cnt = 0; m_dout = 0; m_xo = 0;
        m_wrapped = 0; m_chain = chain; m_token = chain && first_load;
        xo_seen = 0;
        for (int i = 0; i < D; i++) m_mem[i] = 0;
        repeat (HOLD) @(posedge clk);
    endtask

    function automatic int pat(int i);
        return ((i * 37) + 5 + ((i & 1) << 8)) & 9'h1FF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: values held during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 empty_n in reset", empty_n, 0);
        chk("R1 full_n in reset", full_n, 1);
        chk("R1 half_xo_n in reset", half_xo_n, 1);
        chk("R1 dout in reset", dout, 0);
        do_reset(0, 0);
        check_state("R1 after reset");

        // R4: read while empty
        strobe(0, 1, 0, HOLD, "R4 read empty");

        // R2 R5 R12: partial fill, a long-held strobe, partial drain
        for (int i = 0; i < 5; i++) strobe(1, 0, pat(i), (i == 2) ? 25 : HOLD, "R2 R12 write");
        for (int i = 0; i < 3; i++) strobe(0, 1, 0, (i == 1) ? 25 : HOLD, "R2 R12 read");

        // R7: rewind and replay from word 0
        retransmit("R7 rewind");
        for (int i = 0; i < 5; i++) strobe(0, 1, 0, HOLD, "R7 replay");
        strobe(0, 1, 0, HOLD, "R4 read after drain");

        // R5 R6: sweep through every fill level, wrapping the write side
        for (int i = 0; i < D + 5; i++) strobe(1, 0, pat(i + 40), HOLD, "R5 R6 fill");
        strobe(1, 0, 9'h155, HOLD, "R3 write full");
        // R8: rewind refused after a wrap
        retransmit("R8 refused");
        for (int i = 0; i < D; i++) strobe(0, 1, 0, HOLD, "R2 R3 R8 drain");

        // R9: simultaneous write and read at several levels
        for (int i = 0; i < 9; i++) strobe(1, 0, pat(i + 90), HOLD, "R9 prefill");
        for (int i = 0; i < 4; i++) strobe(1, 1, pat(i + 120), HOLD, "R9 both");
        for (int i = 0; i < 9; i++) strobe(0, 1, 0, HOLD, "R9 drain");
        strobe(1, 1, pat(7), HOLD, "R9 both at empty");
        strobe(0, 1, 0, HOLD, "R9 drain last");

        // R10 R11: chained mode with the first-load mark
        do_reset(1, 1);
        check_state("R1 chained reset");
        for (int i = 0; i < D; i++) strobe(1, 0, pat(i + 200), HOLD, "R10 R11 fill");
        chk("R10 handoff pulses", xo_seen, m_xo);
        strobe(0, 1, 0, HOLD, "R11 read one");
        strobe(1, 0, 9'h0AA, HOLD, "R11 write without token");
        pulse_xi();
        strobe(1, 0, 9'h1AA, HOLD, "R11 write with token");
        retransmit("R7 ignored in chained mode");
        for (int i = 0; i < D; i++) strobe(0, 1, 0, HOLD, "R2 R11 chained drain");
        chk("R10 handoff pulses final", xo_seen, m_xo);

        // R11: chained buffer without first-load holds no token
        do_reset(1, 0);
        strobe(1, 0, 9'h033, HOLD, "R11 no first load");
        pulse_xi();
        strobe(1, 0, 9'h133, HOLD, "R11 token granted");
        strobe(0, 1, 0, HOLD, "R11 read granted word");
        chk("R10 no pulse without wrap", xo_seen, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule